// File: doc/BRIEF.md
# SPI NOR Programmed Command Shifter

This block runs one short, software-composed transaction on a serial NOR flash and keeps the bits that come back. Software fills up to six byte-wide outgoing data registers and a bit-count register, then writes a start code into the command register. The engine pulls chip select low and runs the requested number of serial clocks on one data line in each direction. When the clock count is reached it releases chip select, leaves the received bits in a bank of result registers and clears the command register, which software polls to detect completion.

Two more start codes cover the common status accesses. One sends the read-status opcode itself and keeps the returned byte in a status register. The other sends the write-status opcode and then the loaded data bits. The serial clock is a fixed division of the system clock, idles low, launches data on its falling edge and samples on its rising edge.

Top module: `spi_cmd_shifter`

## Requirements
- R1: Register byte addresses: 0 command, 1 bit count, 2 status byte (read only), 8+i data register i (i = 0..5), 16+k result register k (k = 0..4). After reset every register reads 0, cs_n is high and sck is low.
- R2: Writing 0x04 to the command register starts a programmed transfer of exactly N sck rising edges, N being the bit count. cs_n stays low from before the first edge until after the last, and sck is low whenever cs_n is high.
- R3: In a programmed transfer the outgoing bits are the data registers taken as one word with register 5 on top, sent MSB first (register 5, then 4, down to 0). Bits sent after the 48th are 0. mosi changes only while sck is low.
- R4: Every bit sampled on miso is shifted into the result bank as one long shift register whose newest bit lands in bit 0 of result register 0, so older bits move toward result register 4 and carry over across transfers. After a 32-clock transfer, result registers 2, 1 and 0 hold the first, second and third bytes returned after the opcode.
- R5: The command register reads back the written code while the transfer runs and reads 0 from the cycle chip select is released.
- R6: Code 0x02 runs a 16-clock transfer that sends opcode 0x05 followed by zeros; the last 8 received bits are stored in the status register. The bit count is not used.
- R7: Code 0x20 sends opcode 0x01 followed by the first N bits of the data stack (as in R3), for N + 8 clocks in all.
- R8: While a transfer runs, writes to every register, including a new start code, are ignored.
- R9: A command write with a code other than 0x04, 0x02 or 0x20, or a 0x04 start with a bit count of 0, starts nothing: chip select does not move and the command register reads 0.
- R10: Each sck half period lasts HALF_DIV system clocks (default 2, so 20 ns per sck period at 200 MHz); the first rising edge comes one half period after cs_n falls, and cs_n rises one half period after the last falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write byte address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 5 | Register read byte address |
| rd_data | output | 8 | Register read data (combinational) |
| sck | output | 1 | Serial clock to the flash |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
The hardest situation to reach is a register write landing in the middle of a running transfer, where a missed busy guard would silently retarget the count, the data stack or the command. The bench starts a long programmed transfer, then writes a data register, the count and a new start code while chip select is low, and afterwards confirms one chip-select cycle, the original edge count and the untouched register contents. The carry-over of result bits from one transfer into the next is reached by walking the vector table in order against a running model of the result bank.

// File: rtl/scs_pkg.sv
package scs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_TAIL  = 2'd3
  } scs_state_t;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PROG = 2'd1,
    OP_RDST = 2'd2,
    OP_WRST = 2'd3
  } scs_op_t;

  localparam logic [7:0] CODE_PROG = 8'h04;
  localparam logic [7:0] CODE_RDST = 8'h02;
  localparam logic [7:0] CODE_WRST = 8'h20;

endpackage

// File: rtl/scs_tick_gen.sv
module scs_tick_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/scs_tx_shifter.sv
module scs_tx_shifter #(
  parameter int TXW = 56
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [TXW-1:0] load_val,
  input  logic           shift_en,
  output logic           mosi
);
  logic [TXW-1:0] sr_q, sr_d;

  assign mosi = sr_q[TXW-1];

  always_comb begin
    sr_d = sr_q;
    if (load)          sr_d = load_val;
    else if (shift_en) sr_d = {sr_q[TXW-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end
endmodule

// File: rtl/scs_rx_bank.sv
module scs_rx_bank #(
  parameter int NRES = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [8*NRES-1:0] bank
);
  localparam int RXW = 8 * NRES;

  logic [RXW-1:0] bank_q, bank_d;

  assign bank = bank_q;

  always_comb begin
    bank_d = bank_q;
    if (shift_en) bank_d = {bank_q[RXW-2:0], bit_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_q <= '0;
    else        bank_q <= bank_d;
  end
endmodule

// File: rtl/scs_ctrl.sv
module scs_ctrl
  import scs_pkg::*;
#(
  parameter int BW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [BW-1:0] total,
  input  logic          tick,
  output logic          busy,
  output logic          sck,
  output logic          cs_n,
  output logic          tx_shift,
  output logic          rx_sample,
  output logic          done
);
  scs_state_t    state_q, state_d;
  logic          sck_q, sck_d;
  logic          csn_q, csn_d;
  logic [BW-1:0] left_q, left_d;

  assign busy = (state_q != ST_IDLE);
  assign sck  = sck_q;
  assign cs_n = csn_q;

  always_comb begin
    state_d   = state_q;
    sck_d     = sck_q;
    csn_d     = csn_q;
    left_d    = left_q;
    tx_shift  = 1'b0;
    rx_sample = 1'b0;
    done      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_LEAD;
          csn_d   = 1'b0;
          left_d  = total;
        end
      end
      ST_LEAD: begin
        if (tick) begin
          sck_d     = 1'b1;
          rx_sample = 1'b1;
          state_d   = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (tick) begin
          if (sck_q) begin
            sck_d = 1'b0;
            if (left_q == BW'(1)) begin
              left_d  = '0;
              state_d = ST_TAIL;
            end else begin
              left_d   = left_q - 1'b1;
              tx_shift = 1'b1;
            end
          end else begin
            sck_d     = 1'b1;
            rx_sample = 1'b1;
          end
        end
      end
      ST_TAIL: begin
        if (tick) begin
          csn_d   = 1'b1;
          done    = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sck_q   <= 1'b0;
      csn_q   <= 1'b1;
      left_q  <= '0;
    end else begin
      state_q <= state_d;
      sck_q   <= sck_d;
      csn_q   <= csn_d;
      left_q  <= left_d;
    end
  end
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter
  import scs_pkg::*;
#(
  parameter int         HALF_DIV = 2,
  parameter int         NDATA    = 6,
  parameter int         NRES     = 5,
  parameter int         CNT_W    = 8,
  parameter int         AW       = 5,
  parameter logic [7:0] RDST_OP  = 8'h05,
  parameter logic [7:0] WRST_OP  = 8'h01
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          sck,
  output logic          cs_n,
  output logic          mosi,
  input  logic          miso
);
  localparam int TXW       = 8 * (NDATA + 1);
  localparam int STW       = 8 * NDATA;
  localparam int RXW       = 8 * NRES;
  localparam int BW        = CNT_W + 1;
  localparam int A_CMD     = 0;
  localparam int A_CNT     = 1;
  localparam int A_STAT    = 2;
  localparam int DATA_BASE = 8;
  localparam int RES_BASE  = DATA_BASE + 8;

  logic [7:0]       cmd_q, cmd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [7:0]       stat_q, stat_d;
  logic [7:0]       data_q [NDATA];
  logic [7:0]       data_d [NDATA];

  logic             busy, tick, done, tx_shift, rx_sample;
  logic             cmd_wr_hit, cfg_wr, accept;
  scs_op_t          op_w;
  logic [BW-1:0]    total_w;
  logic [STW-1:0]   stack_w;
  logic [TXW-1:0]   tx_load_w;
  logic [RXW-1:0]   bank_w;

  // data stack, highest register on top
  always_comb begin
    for (int i = 0; i < NDATA; i++) stack_w[8*i +: 8] = data_q[i];
  end

  // command decode and transfer sizing
  assign cmd_wr_hit = wr_en && (wr_addr == AW'(A_CMD));
  assign cfg_wr     = wr_en && !busy;

  always_comb begin
    op_w      = OP_NONE;
    total_w   = '0;
    tx_load_w = '0;
    unique case (wr_data)
      CODE_PROG: begin
        op_w      = OP_PROG;
        total_w   = {1'b0, cnt_q};
        tx_load_w = {stack_w, 8'h00};
      end
      CODE_RDST: begin
        op_w      = OP_RDST;
        total_w   = BW'(16);
        tx_load_w = {RDST_OP, {STW{1'b0}}};
      end
      CODE_WRST: begin
        op_w      = OP_WRST;
        total_w   = {1'b0, cnt_q} + BW'(8);
        tx_load_w = {WRST_OP, stack_w};
      end
      default: op_w = OP_NONE;
    endcase
  end

  assign accept = cmd_wr_hit && !busy && (op_w != OP_NONE) && (total_w != '0);

  // register file next state
  always_comb begin
    cmd_d  = cmd_q;
    cnt_d  = cnt_q;
    stat_d = stat_q;
    for (int i = 0; i < NDATA; i++) data_d[i] = data_q[i];

    if (accept) cmd_d = wr_data;
    else if (done) cmd_d = '0;

    if (done && (cmd_q == CODE_RDST)) stat_d = bank_w[7:0];

    if (cfg_wr && (wr_addr == AW'(A_CNT))) cnt_d = wr_data[CNT_W-1:0];
    for (int i = 0; i < NDATA; i++) begin
      if (cfg_wr && (wr_addr == AW'(DATA_BASE + i))) data_d[i] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      cnt_q  <= '0;
      stat_q <= '0;
      for (int i = 0; i < NDATA; i++) data_q[i] <= '0;
    end else begin
      cmd_q  <= cmd_d;
      cnt_q  <= cnt_d;
      stat_q <= stat_d;
      for (int i = 0; i < NDATA; i++) data_q[i] <= data_d[i];
    end
  end

  // read mux
  always_comb begin
    rd_data = '0;
    if (rd_addr == AW'(A_CMD))  rd_data = cmd_q;
    if (rd_addr == AW'(A_CNT))  rd_data = 8'(cnt_q);
    if (rd_addr == AW'(A_STAT)) rd_data = stat_q;
    for (int i = 0; i < NDATA; i++) begin
      if (rd_addr == AW'(DATA_BASE + i)) rd_data = data_q[i];
    end
    for (int k = 0; k < NRES; k++) begin
      if (rd_addr == AW'(RES_BASE + k)) rd_data = bank_w[8*k +: 8];
    end
  end

  scs_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .tick  (tick)
  );

  scs_ctrl #(.BW(BW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .total     (total_w),
    .tick      (tick),
    .busy      (busy),
    .sck       (sck),
    .cs_n      (cs_n),
    .tx_shift  (tx_shift),
    .rx_sample (rx_sample),
    .done      (done)
  );

  scs_tx_shifter #(.TXW(TXW)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (tx_load_w),
    .shift_en (tx_shift),
    .mosi     (mosi)
  );

  scs_rx_bank #(.NRES(NRES)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (rx_sample),
    .bit_in   (miso),
    .bank     (bank_w)
  );
endmodule

// File: rtl/scs_checker.sv
module scs_checker #(
  parameter int BW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sck,
  input logic          cs_n,
  input logic          mosi,
  input logic          busy,
  input logic          done,
  input logic          accept,
  input logic          cmd_wr_hit,
  input logic [BW-1:0] total,
  input logic [7:0]    cmd_q
);
  logic          sck_prev_q;
  logic [BW-1:0] rises_q;
  logic [BW-1:0] total_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev_q <= 1'b0;
      rises_q    <= '0;
      total_q    <= '0;
    end else begin
      sck_prev_q <= sck;
      if (accept) begin
        rises_q <= '0;
        total_q <= total;
      end else if (sck && !sck_prev_q) begin
        rises_q <= rises_q + 1'b1;
      end
    end
  end

  // R2: lines idle while no transfer runs
  p_idle_lines_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && !sck));

  // R2: clock pulses only inside chip select
  p_sck_in_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> !cs_n);

  // R3: data steady while the clock is high
  p_mosi_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));

  // R5: command cleared when chip select is released
  p_cmd_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (cmd_q == 8'h00));

  // R5: code held for the whole transfer
  p_cmd_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (cmd_q != 8'h00));

  // R8: command write during a transfer is ignored
  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && cmd_wr_hit) |=> $stable(cmd_q));

  // R2 / R10: edge count matches the requested length
  p_edge_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rises_q == total_q));
endmodule

bind spi_cmd_shifter scs_checker #(.BW(BW)) u_scs_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .sck        (sck),
  .cs_n       (cs_n),
  .mosi       (mosi),
  .busy       (busy),
  .done       (done),
  .accept     (accept),
  .cmd_wr_hit (cmd_wr_hit),
  .total      (total_w),
  .cmd_q      (cmd_q)
);

// File: tb/tb_spi_cmd_shifter.sv
`timescale 1ns/1ps
module tb_spi_cmd_shifter;
  localparam int  HALF = 2;
  localparam real TCLK = 5.0;
  localparam int  NV   = 7;

  localparam logic [7:0]  V_CODE [NV] = '{8'h04, 8'h04, 8'h04, 8'h04, 8'h02, 8'h20, 8'h04};
  localparam logic [7:0]  V_CNT  [NV] = '{8'd8, 8'd32, 8'd32, 8'd48, 8'd0, 8'd8, 8'd56};
  localparam logic [47:0] V_DATA [NV] = '{48'h06_0000000000, 48'h9F_0000000000,
                                          48'h20_123456_0000, 48'hA5C30F1E7788,
                                          48'h0, 48'h3C_0000000000, 48'h112233445566};
  localparam logic [63:0] V_RESP [NV] = '{64'h0, 64'hFFC2201600000000,
                                          64'h00000000_00000000, 64'h0123456789ABCDEF,
                                          64'h005A000000000000, 64'hFFFF000000000000,
                                          64'hFFFFFFFFFFFFFFFF};

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [4:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       sck, cs_n, mosi, miso;

  int total_chk = 0;
  int bad_chk   = 0;

  // flash-side model
  logic [63:0] resp_pat = '0;
  logic [63:0] resp_sh  = '0;
  logic [63:0] cap      = '0;
  int          rises    = 0;
  int          cs_falls = 0;
  realtime     t_csf, t_r1, t_r2, t_lf, t_csr;
  logic [39:0] exp_bank = '0;

  assign miso = resp_sh[63];

  always #(TCLK/2) clk = ~clk;

  spi_cmd_shifter dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  always @(negedge cs_n) begin
    resp_sh  = resp_pat;
    cap      = '0;
    rises    = 0;
    cs_falls = cs_falls + 1;
    t_csf    = $realtime;
  end
  always @(posedge cs_n) t_csr = $realtime;
  always @(posedge sck) begin
    cap   = {cap[62:0], mosi};
    rises = rises + 1;
    if (rises == 1) t_r1 = $realtime;
    if (rises == 2) t_r2 = $realtime;
  end
  always @(negedge sck) begin
    resp_sh = {resp_sh[62:0], 1'b0};
    t_lf    = $realtime;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total_chk++;
    if (!ok) begin
      bad_chk++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    rd_addr = a;
    #0.5;
    d = rd_data;
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      rd(5'd0, v);
      if (v == 8'h00) break;
    end
  endtask

  task automatic check_bank(input string req);
    logic [7:0]  v;
    logic [39:0] got;
    for (int k = 0; k < 5; k++) begin
      rd(5'(16 + k), v);
      got[8*k +: 8] = v;
    end
    check(got == exp_bank, req, "result bank", 64'(got), 64'(exp_bank));
  endtask

  task automatic run_vec(input int v);
    logic [7:0]  c;
    logic [63:0] exp_cap;
    int          n;
    logic        sb;
    resp_pat = V_RESP[v];
    wr(5'd1, V_CNT[v]);
    for (int i = 0; i < 6; i++) wr(5'(8 + i), V_DATA[v][8*i +: 8]);
    wr(5'd0, V_CODE[v]);
    rd(5'd0, c);
    check(c == V_CODE[v], "R5", "code while busy", 64'(c), 64'(V_CODE[v]));
    wait_idle();
    rd(5'd0, c);
    check(c == 8'h00, "R5", "code after done", 64'(c), 64'h0);

    if (V_CODE[v] == 8'h02)      n = 16;
    else if (V_CODE[v] == 8'h20) n = int'(V_CNT[v]) + 8;
    else                         n = int'(V_CNT[v]);
    exp_cap = '0;
    for (int i = 0; i < n; i++) begin
      if (V_CODE[v] == 8'h02)      sb = (i < 8) ? 1'(8'h05 >> (7 - i)) : 1'b0;
      else if (V_CODE[v] == 8'h20) sb = (i < 8) ? 1'(8'h01 >> (7 - i))
                                                : ((i < 56) ? V_DATA[v][55 - i] : 1'b0);
      else                         sb = (i < 48) ? V_DATA[v][47 - i] : 1'b0;
      exp_cap  = {exp_cap[62:0], sb};
      exp_bank = {exp_bank[38:0], (i < 64) ? V_RESP[v][63 - i] : 1'b0};
    end
    check(rises == n, (V_CODE[v] == 8'h20) ? "R7" : "R2", "sck rises",
          64'(rises), 64'(n));
    check(cap == exp_cap, (V_CODE[v] == 8'h04) ? "R3" : "R6/R7", "sent bits",
          cap, exp_cap);
    check_bank("R4");
    if (V_CODE[v] == 8'h02) begin
      rd(5'd2, c);
      check(c == exp_bank[7:0], "R6", "status byte", 64'(c), 64'(exp_bank[7:0]));
      check(c == 8'h5A, "R6", "status value", 64'(c), 64'h5A);
    end
    if (v == 1) begin
      rd(5'd18, c); check(c == 8'hC2, "R4", "id byte in result 2", 64'(c), 64'hC2);
      rd(5'd17, c); check(c == 8'h20, "R4", "id byte in result 1", 64'(c), 64'h20);
      rd(5'd16, c); check(c == 8'h16, "R4", "id byte in result 0", 64'(c), 64'h16);
    end
    if (v == 0) begin
      check((t_r1 - t_csf) == 2.0 * HALF * TCLK / 2 * 2 / 2 * 1.0, "R10", "cs lead ns",
            64'(int'(t_r1 - t_csf)), 64'(HALF * 5));
      check((t_r2 - t_r1) == 2.0 * HALF * TCLK, "R10", "sck period ns",
            64'(int'(t_r2 - t_r1)), 64'(HALF * 10));
      check((t_csr - t_lf) == HALF * TCLK, "R10", "cs trail ns",
            64'(int'(t_csr - t_lf)), 64'(HALF * 5));
    end
  endtask

  initial begin
    #900000;
    total_chk++;
    bad_chk++;
    $display("FAIL watchdog expired actual=%h expected=%h", 64'h0, 64'h1);
    $display("  test done: total=%0d bad=%0d", total_chk, bad_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int         falls0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(cs_n == 1'b1 && sck == 1'b0, "R1", "lines after reset",
          64'({cs_n, sck}), 64'h2);
    rd(5'd0, v);  check(v == 8'h00, "R1", "command reset", 64'(v), 64'h0);
    rd(5'd1, v);  check(v == 8'h00, "R1", "count reset", 64'(v), 64'h0);
    rd(5'd2, v);  check(v == 8'h00, "R1", "status reset", 64'(v), 64'h0);
    rd(5'd13, v); check(v == 8'h00, "R1", "data5 reset", 64'(v), 64'h0);
    check_bank("R1");

    // table walk
    for (int vi = 0; vi < NV; vi++) run_vec(vi);

    // R8 writes ignored while busy
    wr(5'd8, 8'h11);
    wr(5'd1, 8'd16);
    resp_pat = '0;
    falls0 = cs_falls;
    wr(5'd0, 8'h04);
    repeat (3) @(negedge clk);
    wr(5'd8, 8'hEE);
    wr(5'd1, 8'h40);
    wr(5'd0, 8'h02);
    wait_idle();
    repeat (10) @(negedge clk);
    for (int i = 0; i < 16; i++) exp_bank = {exp_bank[38:0], 1'b0};
    check(cs_falls == falls0 + 1, "R8", "one transfer only", 64'(cs_falls), 64'(falls0 + 1));
    check(rises == 16, "R8", "length kept", 64'(rises), 64'd16);
    rd(5'd1, v);  check(v == 8'd16, "R8", "count kept", 64'(v), 64'd16);
    rd(5'd8, v);  check(v == 8'h11, "R8", "data0 kept", 64'(v), 64'h11);
    rd(5'd0, v);  check(v == 8'h00, "R8", "command idle", 64'(v), 64'h0);

    // R9 zero count and unknown code
    falls0 = cs_falls;
    wr(5'd1, 8'd0);
    wr(5'd0, 8'h04);
    rd(5'd0, v);  check(v == 8'h00, "R9", "zero count not started", 64'(v), 64'h0);
    wr(5'd1, 8'd8);
    wr(5'd0, 8'h13);
    rd(5'd0, v);  check(v == 8'h00, "R9", "unknown code not started", 64'(v), 64'h0);
    repeat (20) @(negedge clk);
    check(cs_falls == falls0 && cs_n == 1'b1, "R9", "chip select quiet",
          64'(cs_falls), 64'(falls0));
    check_bank("R9");

    $display("  test done: total=%0d bad=%0d", total_chk, bad_chk);
    $finish;
  end
endmodule